// File: doc/BRIEF.md
# Cascadable Four-Channel Down-Counter Group

This block holds four periodic down-counting timers behind one small register-mapped write/read port. Each timer reloads from a programmable base count, flips a toggle flag and raises a one-cycle interrupt pulse every time it expires. All four timers share a prescaler. The prescaler divides the block clock by 8, 16, 32 or 64 to make the count tick.

A shared control register can chain neighbouring timers into longer counters. In a chained pair the lower-numbered timer counts the ticks. Each time it reaches zero, it steps the higher-numbered timer once. The higher timer carries the start/stop control and is the only one of the pair that signals expiry. A per-pair rollover option makes the lower timer reload to its full range, not to its base, after each wrap. This allows very long intervals. Chains may span three or four timers.

Top module: `cascade_timer_group`

## Requirements
- R1: Timer n (0..3) decodes at byte address n*0x40 with four registers at a 0x10 stride: +0x00 count, +0x10 base, +0x20 vector, +0x30 destination. Address bits 3:0 are ignored. The control register sits at 0x100. Only control bits 2:0, 9:8 and 26:24 are writable, and every other control bit reads 0.
- R2: After a synchronous active-low reset, every base register reads 0x8000_0000 (inhibited, reload 0). Counts, toggles, vector and destination registers read 0. The control register reads 0 (divide by 8), and no interrupt is raised.
- R3: Control bits 9:8 (value f) set the tick rate to one tick every 8*2^f clock cycles, counted by a free-running prescaler.
- R4: Base register bit 31 is the inhibit bit and bits 30:0 are the reload value. A base write to a timer that is not running also loads its count. A base write to a running timer changes only the value used at its next reload.
- R5: On each tick, a running timer whose count is nonzero decrements. If the count is zero, the timer reloads, inverts its toggle flag (count register bit 31) and raises its interrupt for exactly one cycle, in the cycle after the reload edge. The period is base+1 ticks.
- R6: While a timer is not running, its count and toggle flag stay unchanged.
- R7: Writes to a count register are ignored.
- R8: Control bit k (k=0..2) chains timer k (lower) to timer k+1 (upper). The lower timer runs only while it is not inhibited and its upper timer is running. The lower timer's zero events replace the tick as the upper timer's count step. The lower timer raises no interrupt.
- R9: Control bit 24+k enables rollover for the pair k/k+1. When chaining and rollover are both on, the lower timer reloads to 0x7FFF_FFFF instead of its base.
- R10: Vector and destination registers store and read back any 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 9 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 4 | Per-timer one-cycle expiry pulses |

## Verification
A lone timer is first run with a small base value, then its base is changed while it runs. This separates an immediate reload from one deferred to the next expiry. The same timer is then run at all four prescale settings, with the ratio changed mid-count, which exposes any error in the tick spacing. A two-timer chain, a chain with rollover and a three-timer chain show whether zero events propagate upward and whether the lower timer's interrupt is masked. They also show whether the rollover reload value is used in place of the base. Two unchained timers running side by side, inhibited timers and writes to the count registers check that the channels stay independent and that held state really holds.

// File: rtl/ctg_pkg.sv
// Package: shared constants and register encodings of the timer group.
// Assumes a 32-bit data path with the count field one bit narrower.
package ctg_pkg;

    localparam int N_TMR     = 4;
    localparam int DATA_W    = 32;
    localparam int DIV_W     = 2;
    localparam int BASE_LOG2 = 3;
    localparam int DIV_LSB   = 8;
    localparam int ROLL_LSB  = 24;

    // Per-timer register slot selected by address bits 5:4
    typedef enum logic [1:0] {
        REG_COUNT = 2'd0,
        REG_BASE  = 2'd1,
        REG_VEC   = 2'd2,
        REG_DEST  = 2'd3
    } ctg_reg_e;

    // Writable bits of the control register
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0700_0307;

endpackage

// File: rtl/ctg_prescaler.sv
// Module: free-running clock prescaler.
// Emits a single-cycle tick every (2^BASE_LOG2 << div_sel) cycles.
// Assumes div_sel may change at any time; a count beyond the new
// limit ticks at once and restarts, so the counter never sticks.
module ctg_prescaler #(
    parameter int DIV_W     = 2,
    parameter int BASE_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int CW = BASE_LOG2 + (1 << DIV_W) - 1;

    logic [CW-1:0] cnt_q;
    logic [CW:0]   limit;

    // Terminal count for the selected ratio
    always_comb begin
        limit = ((CW+1)'(1) << (BASE_LOG2 + int'(div_sel))) - (CW+1)'(1);
        tick  = ({1'b0, cnt_q} >= limit);
    end

    // Advance or restart the divider counter
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/ctg_channel.sv
// Module: one down-counting timer channel with its register storage.
// Counts on 'step' while 'run' is high; at zero it reloads from the base
// (or the full range when reload_max is set) and flips its toggle flag.
// Assumes run and step are produced by the group's chaining logic.
module ctg_channel #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              run,
    input  logic              reload_max,
    input  logic              wr_base,
    input  logic              wr_vec,
    input  logic              wr_dest,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic              tog,
    output logic [CNT_W-1:0]  base,
    output logic              inh,
    output logic [DATA_W-1:0] vec,
    output logic [DATA_W-1:0] dest,
    output logic              zero
);
    logic [CNT_W-1:0] cnt_q, base_q;
    logic             tog_q, inh_q;
    logic [DATA_W-1:0] vec_q, dest_q;

    // Expiry event of this channel in the current cycle
    assign zero = step && run && (cnt_q == '0);

    // Count, toggle and base register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tog_q  <= 1'b0;
            base_q <= '0;
            inh_q  <= 1'b1;
        end else begin
            if (wr_base) begin
                base_q <= wdata[CNT_W-1:0];
                inh_q  <= wdata[DATA_W-1];
                if (!run) cnt_q <= wdata[CNT_W-1:0];
            end
            if (run && step) begin
                if (cnt_q == '0) begin
                    cnt_q <= reload_max ? {CNT_W{1'b1}} : base_q;
                    tog_q <= ~tog_q;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    // Vector and destination storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            dest_q <= '0;
        end else begin
            if (wr_vec)  vec_q  <= wdata;
            if (wr_dest) dest_q <= wdata;
        end
    end

    assign cnt  = cnt_q;
    assign tog  = tog_q;
    assign base = base_q;
    assign inh  = inh_q;
    assign vec  = vec_q;
    assign dest = dest_q;
endmodule

// File: rtl/cascade_timer_group.sv
// Module: four-timer group with shared prescaler, control register,
// register decode and pairwise chaining. Interrupt pulses are registered.
// Assumes single-cycle writes; reads are combinational on bus_addr.
module cascade_timer_group (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [8:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [3:0]  irq
);
    import ctg_pkg::*;

    localparam int N     = N_TMR;
    localparam int CNT_W = DATA_W - 1;

    logic [DATA_W-1:0] ctrl_q;
    logic [N-2:0]      casc, roll;
    logic [DIV_W-1:0]  div_sel;
    logic              tick;

    logic              sel_ctrl;
    logic [1:0]        sel_t;
    ctg_reg_e          sel_r;
    logic              unused_low;

    logic [N-1:0] run, step, zero, inh, tog, rmax, wr_base, wr_vec, wr_dest, irq_nx;
    logic [CNT_W-1:0]  cnt_a  [N];
    logic [CNT_W-1:0]  base_a [N];
    logic [DATA_W-1:0] vec_a  [N];
    logic [DATA_W-1:0] dest_a [N];
    logic [N-1:0]      irq_q;

    assign sel_ctrl   = bus_addr[8];
    assign sel_t      = bus_addr[7:6];
    assign sel_r      = ctg_reg_e'(bus_addr[5:4]);
    assign unused_low = ^bus_addr[3:0];

    assign casc    = ctrl_q[N-2:0];
    assign roll    = ctrl_q[ROLL_LSB +: N-1];
    assign div_sel = ctrl_q[DIV_LSB +: DIV_W];

    // Control register write with reserved bits forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                  ctrl_q <= '0;
        else if (bus_wr && sel_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
    end

    ctg_prescaler #(.DIV_W(DIV_W), .BASE_LOG2(BASE_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tick(tick)
    );

    for (genvar i = 0; i < N; i++) begin : g_tmr
        // Register strobes for this channel
        assign wr_base[i] = bus_wr && !sel_ctrl && (sel_t == 2'(i)) && (sel_r == REG_BASE);
        assign wr_vec[i]  = bus_wr && !sel_ctrl && (sel_t == 2'(i)) && (sel_r == REG_VEC);
        assign wr_dest[i] = bus_wr && !sel_ctrl && (sel_t == 2'(i)) && (sel_r == REG_DEST);

        // Run enable: a chained lower channel follows its upper neighbour
        if (i == N-1) begin : g_top
            assign run[i]    = !inh[i];
            assign rmax[i]   = 1'b0;
            assign irq_nx[i] = zero[i];
        end else begin : g_low
            assign run[i]    = !inh[i] && (!casc[i] || run[i+1]);
            assign rmax[i]   = casc[i] && roll[i];
            assign irq_nx[i] = zero[i] && !casc[i];
        end

        // Count step: prescaler tick, or the lower neighbour's expiry
        if (i == 0) begin : g_first
            assign step[i] = tick;
        end else begin : g_next
            assign step[i] = casc[i-1] ? zero[i-1] : tick;
        end

        ctg_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .step(step[i]), .run(run[i]), .reload_max(rmax[i]),
            .wr_base(wr_base[i]), .wr_vec(wr_vec[i]), .wr_dest(wr_dest[i]),
            .wdata(bus_wdata),
            .cnt(cnt_a[i]), .tog(tog[i]), .base(base_a[i]), .inh(inh[i]),
            .vec(vec_a[i]), .dest(dest_a[i]), .zero(zero[i])
        );
    end

    // Register the interrupt pulses
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_nx;
    end
    assign irq = irq_q;

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata = ctrl_q;
        end else begin
            unique case (sel_r)
                REG_COUNT: bus_rdata = {tog[sel_t], cnt_a[sel_t]};
                REG_BASE:  bus_rdata = {inh[sel_t], base_a[sel_t]};
                REG_VEC:   bus_rdata = vec_a[sel_t];
                REG_DEST:  bus_rdata = dest_a[sel_t];
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cascade_timer_group_chk.sv
// Checker: temporal properties of the timer group, bound to the top.
// Assumes observation of internal run/inhibit/toggle state via bind.
module cascade_timer_group_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  irq,
    input logic [2:0]  casc,
    input logic        tick,
    input logic [3:0]  inh,
    input logic [3:0]  tog,
    input logic [3:0]  run,
    input logic [3:0]  wr_base,
    input logic [30:0] cnt3,
    input logic [31:0] wdata
);
    // R3: prescaler ticks are never back to back
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R8: a chained lower timer never raises an interrupt
    p_lower_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        casc[0] |=> !irq[0]);

    // R6: an inhibited timer with no base write holds count and toggle
    p_hold_inhibited_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inh[3] && !wr_base[3]) |=> ($stable(cnt3) && $stable(tog[3])));

    // R5: the interrupt pulse coincides with a toggle flip
    p_irq_flips_tog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq[3] |-> (tog[3] != $past(tog[3])));

    // R5: no toggle flip without an interrupt on the top timer
    p_tog_needs_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq[3] |-> $stable(tog[3]));

    // R4: a base write to a stopped timer loads its count
    p_stopped_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_base[3] && !run[3]) |=> (cnt3 == $past(wdata[30:0])));
endmodule

bind cascade_timer_group cascade_timer_group_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .casc(ctrl_q[2:0]), .tick(tick),
    .inh(inh), .tog(tog), .run(run), .wr_base(wr_base),
    .cnt3(cnt_a[3]), .wdata(bus_wdata)
);

// File: tb/sim_cascade_timer_group.sv
// Bench: behavioural reference model compared with the design every clock.
module sim_cascade_timer_group;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [8:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string req = "R2";

    // Reference state
    int         m_cur [4];
    int         m_base[4];
    bit         m_inh [4];
    bit         m_tog [4];
    bit [31:0]  m_vec [4];
    bit [31:0]  m_dest[4];
    bit [31:0]  m_ctrl;
    int         m_pcnt;
    bit [3:0]   m_irq;

    always #10 clk = ~clk;

    cascade_timer_group u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (addr %h, t=%0t)", tag, act, exp, bus_addr, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [8:0] a);
        int t;
        t = int'(a[7:6]);
        if (a[8]) return m_ctrl;
        case (a[5:4])
            2'd0: return {m_tog[t], 31'(m_cur[t])};
            2'd1: return {m_inh[t], 31'(m_base[t])};
            2'd2: return m_vec[t];
            default: return m_dest[t];
        endcase
    endfunction

    // Reference model: one step per clock from the pre-edge state
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_cur[i] = 0; m_base[i] = 0; m_inh[i] = 1; m_tog[i] = 0;
                m_vec[i] = 0; m_dest[i] = 0;
            end
            m_ctrl = 0; m_pcnt = 0; m_irq = 0;
        end else begin
            bit tk;
            bit rn[5];
            bit st[4];
            bit zr[4];
            int n_cur[4];
            int n_base[4];
            bit n_inh[4];
            bit n_tog[4];
            bit [31:0] n_ctrl;
            tk = (m_pcnt >= (8 << m_ctrl[9:8]) - 1);
            rn[4] = 1;
            for (int i = 3; i >= 0; i--)
                rn[i] = !m_inh[i] && (i == 3 || !m_ctrl[i] || rn[i+1]);
            for (int i = 0; i < 4; i++) begin
                st[i] = (i == 0) ? tk : (m_ctrl[i-1] ? zr[i-1] : tk);
                zr[i] = st[i] && rn[i] && (m_cur[i] == 0);
                n_cur[i] = m_cur[i]; n_base[i] = m_base[i];
                n_inh[i] = m_inh[i]; n_tog[i] = m_tog[i];
            end
            n_ctrl = m_ctrl;
            if (bus_wr) begin
                int t;
                t = int'(bus_addr[7:6]);
                if (bus_addr[8]) n_ctrl = bus_wdata & 32'h0700_0307;
                else case (bus_addr[5:4])
                    2'd1: begin
                        n_base[t] = int'(bus_wdata[30:0]);
                        n_inh[t]  = bus_wdata[31];
                        if (!rn[t]) n_cur[t] = int'(bus_wdata[30:0]);
                    end
                    2'd2: m_vec[t]  = bus_wdata;
                    2'd3: m_dest[t] = bus_wdata;
                    default: ;
                endcase
            end
            for (int i = 0; i < 4; i++) begin
                if (rn[i] && st[i]) begin
                    if (m_cur[i] == 0) begin
                        n_cur[i] = (i < 3 && m_ctrl[i] && m_ctrl[24+i]) ? 32'h7FFF_FFFF : m_base[i];
                        n_tog[i] = !m_tog[i];
                    end else n_cur[i] = m_cur[i] - 1;
                end
                m_irq[i] = zr[i] && !(i < 3 && m_ctrl[i]);
            end
            m_pcnt = tk ? 0 : m_pcnt + 1;
            for (int i = 0; i < 4; i++) begin
                m_cur[i] = n_cur[i]; m_base[i] = n_base[i];
                m_inh[i] = n_inh[i]; m_tog[i] = n_tog[i];
            end
            m_ctrl = n_ctrl;
        end
    end

    // Compare design and model away from the edge
    always @(posedge clk) begin
        #5;
        check({req, " irq"}, {28'd0, irq}, {28'd0, m_irq});
        check({req, " read"}, bus_rdata, exp_read(bus_addr));
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL %s watchdog expired", req);
            finish_run();
        end
    end

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input int n);
        bus_addr = a;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state through the ports
        rd(9'h0D0, 1);
        check("R2 base reset", bus_rdata, 32'h8000_0000);
        check("R2 irq reset", {28'd0, irq}, 32'd0);
        rd(9'h100, 1);
        check("R2 ctrl reset", bus_rdata, 32'd0);

        req = "R10";
        for (int t = 0; t < 4; t++) begin
            wr(9'(t*64 + 'h20), 32'hA500_0000 + t);
            wr(9'(t*64 + 'h30), 32'h5A5A_0F0F ^ t);
        end
        for (int t = 0; t < 4; t++) begin
            rd(9'(t*64 + 'h20), 1);
            check("R10 vector", bus_rdata, 32'hA500_0000 + t);
            rd(9'(t*64 + 'h38), 1);
            check("R10 dest", bus_rdata, 32'h5A5A_0F0F ^ t);
        end

        req = "R1";
        wr(9'h100, 32'hFFFF_FFFF);
        rd(9'h100, 1);
        check("R1 ctrl mask", bus_rdata, 32'h0700_0307);
        wr(9'h100, 32'h0);
        rd(9'h1FC, 2);

        req = "R4";
        wr(9'h0D0, 32'd5);
        rd(9'h0C0, 150);
        wr(9'h0D0, 32'd2);
        rd(9'h0C0, 150);

        req = "R5";
        rd(9'h0C4, 100);

        req = "R3";
        wr(9'h100, 32'h300);
        rd(9'h0C0, 400);
        wr(9'h100, 32'h100);
        rd(9'h0C0, 200);
        wr(9'h100, 32'h200);
        rd(9'h0C0, 200);
        wr(9'h100, 32'h0);

        req = "R6";
        wr(9'h0D0, 32'h8000_0004);
        rd(9'h0C0, 100);

        req = "R7";
        wr(9'h0C0, 32'h0001_2345);
        rd(9'h0C0, 20);
        wr(9'h0D0, 32'd3);
        rd(9'h0C0, 40);
        wr(9'h0C0, 32'h0);
        rd(9'h0C0, 40);

        req = "R5";
        wr(9'h010, 32'd3);
        wr(9'h050, 32'd7);
        for (int k = 0; k < 3; k++) begin
            rd(9'h000, 30);
            rd(9'h040, 30);
        end
        for (int t = 0; t < 4; t++) wr(9'(t*64 + 'h10), 32'h8000_0000);

        req = "R8";
        wr(9'h100, 32'h1);
        wr(9'h010, 32'd2);
        wr(9'h050, 32'h8000_0003);
        wr(9'h050, 32'd3);
        for (int k = 0; k < 6; k++) begin
            rd(9'h000, 50);
            rd(9'h040, 50);
        end

        req = "R9";
        wr(9'h050, 32'h8000_0003);
        wr(9'h100, 32'h0100_0001);
        wr(9'h010, 32'd1);
        wr(9'h050, 32'd3);
        rd(9'h000, 100);
        rd(9'h040, 50);
        wr(9'h050, 32'h8000_0000);

        req = "R8";
        wr(9'h100, 32'h3);
        wr(9'h010, 32'd1);
        wr(9'h050, 32'd1);
        wr(9'h090, 32'd2);
        for (int k = 0; k < 4; k++) begin
            rd(9'h080, 60);
            rd(9'h040, 40);
        end

        finish_run();
    end
endmodule